// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This block presents interrupts to one processor core. Each of its sources has a fixed priority, a vector, a trigger kind (edge or level) and a route. These come in on static configuration inputs. Raise and clear requests arrive one per cycle on a small request port. Sources on the normal route are kept in a raised set. The block compares the best raised source against a current task priority and against the best source already in service, and drives a single interrupt line to the core.

The core interacts through three operations:
- A task-priority write.
- An acknowledge, which returns a vector one cycle later and moves the chosen source into the in-service set.
- An end-of-interrupt, which retires the highest-priority in-service source.

Because a higher-priority request can be presented while a lower one is in service, nesting is supported. Sources routed to the critical or machine-check lines bypass all of this. Each of those lines is asserted while at least one level source on it is active.

Top module: `irq_presenter`

## Requirements
- R1: After reset, the task priority reads 15, the raised and in-service sets are empty, and `irq_o`, `crit_o`, `mcheck_o` and `ack_valid` are low.
- R2: A normal-route raise request is recorded even when its priority is at or below the task priority. A later task-priority write below that priority presents it.
- R3: In the cycle after any event, `irq_o` is high exactly when the best raised priority is strictly greater than the task priority and strictly greater than the best in-service priority, where an empty in-service set counts as lower than every priority.
- R4: Among raised sources of equal priority, the lowest-numbered source is the best. The same rule picks the highest in-service source.
- R5: `ack_re` produces `ack_valid` high for one cycle in the next cycle. `ack_vec` then holds the best raised source's vector, and that source enters service, if its priority exceeds the task priority. Otherwise `ack_vec` holds the spurious vector (default 0xFF).
- R6: Trigger kind is set by `src_level` (1 = level, 0 = edge).
  - An acknowledge removes an edge source from the raised set, and a clear request to an edge source is ignored.
  - A level source stays raised until a clear request arrives.
- R7: `eoi_we` removes the highest-priority in-service source and does nothing when the in-service set is empty.
- R8: While a source is in service, a newly raised source of higher priority (above the task priority) asserts `irq_o` again.
- R9: Route codes per source in `src_route[2i+1:2i]`:
  - 0 and 3 are normal.
  - 1 is critical: `crit_o`.
  - 2 is machine check: `mcheck_o`.
  
  A non-normal line is high while any level source on it is active, regardless of task priority. Edge requests on non-normal routes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_prio | input | NSRC*PRIO_W (32) | Per-source priority, source i at bits [4i+3:4i] |
| src_vec | input | NSRC*VEC_W (64) | Per-source vector |
| src_level | input | NSRC (8) | 1 = level-triggered source |
| src_route | input | 2*NSRC (16) | Per-source route code |
| req_valid | input | 1 | Request strobe |
| req_id | input | IDW (3) | Source number of the request |
| req_level | input | 1 | 1 = raise, 0 = clear |
| ctpr_we | input | 1 | Task-priority write strobe |
| ctpr_wdata | input | PRIO_W (4) | New task priority |
| ctpr_o | output | PRIO_W (4) | Current task priority |
| ack_re | input | 1 | Acknowledge strobe |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vec | output | VEC_W (8) | Acknowledged vector or spurious vector |
| eoi_we | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Normal interrupt to the core |
| crit_o | output | 1 | Critical interrupt line |
| mcheck_o | output | 1 | Machine-check line |

## Verification
The hardest situation to reach is a nested in-service stack where the order of retirement matters. Here an end-of-interrupt must retire the higher of two in-service sources, not the older one. The bench builds that stack by acknowledging a low-priority source, preempting it with a higher one, and then raising a middle-priority source. That source is hidden while the high one is in service and is exposed only if the correct source is retired. A full sweep of source priority against task priority covers the strict-greater comparison at every boundary.

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8,
  parameter logic [VEC_W-1:0] SPUR_VEC = '1,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC*PRIO_W-1:0]  src_prio,
  input  logic [NSRC*VEC_W-1:0]   src_vec,
  input  logic [NSRC-1:0]         src_level,
  input  logic [2*NSRC-1:0]       src_route,
  input  logic                    req_valid,
  input  logic [IDW-1:0]          req_id,
  input  logic                    req_level,
  input  logic                    ctpr_we,
  input  logic [PRIO_W-1:0]       ctpr_wdata,
  output logic [PRIO_W-1:0]       ctpr_o,
  input  logic                    ack_re,
  output logic                    ack_valid,
  output logic [VEC_W-1:0]        ack_vec,
  input  logic                    eoi_we,
  output logic                    irq_o,
  output logic                    crit_o,
  output logic                    mcheck_o
);

  logic [NSRC-1:0]   raised_q, svc_q, act_q;
  logic [NSRC-1:0]   raised_n, svc_n, act_n;
  logic [PRIO_W-1:0] ctpr_q, ctpr_n;
  logic              irq_q, crit_q, mc_q;
  logic [VEC_W-1:0]  ack_vec_q;
  logic              ack_valid_q;

  logic [PRIO_W-1:0] prio [NSRC];
  logic [VEC_W-1:0]  vec  [NSRC];
  logic [NSRC-1:0]   is_norm, is_crit, is_mc;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign prio[g]    = src_prio[g*PRIO_W +: PRIO_W];
    assign vec[g]     = src_vec[g*VEC_W +: VEC_W];
    assign is_crit[g] = src_route[2*g +: 2] == 2'd1;
    assign is_mc[g]   = src_route[2*g +: 2] == 2'd2;
    assign is_norm[g] = !is_crit[g] && !is_mc[g];
  end

  function automatic logic [IDW:0] pick(input logic [NSRC-1:0] s,
                                        input logic [NSRC*PRIO_W-1:0] pr);
    logic hit;
    logic [IDW-1:0] idx;
    logic [PRIO_W-1:0] bp;
    hit = 1'b0; idx = '0; bp = '0;
    for (int i = 0; i < NSRC; i++)
      if (s[i] && (!hit || pr[i*PRIO_W +: PRIO_W] > bp)) begin
        hit = 1'b1;
        idx = IDW'(i);
        bp  = pr[i*PRIO_W +: PRIO_W];
      end
    return {hit, idx};
  endfunction

  logic           r_hit, s_hit, nr_hit, ns_hit;
  logic [IDW-1:0] r_idx, s_idx, nr_idx, ns_idx;
  logic           ack_grant;

  assign {r_hit, r_idx} = pick(raised_q, src_prio);
  assign {s_hit, s_idx} = pick(svc_q, src_prio);
  assign ack_grant = ack_re && r_hit && (prio[r_idx] > ctpr_q);
  assign ctpr_n    = ctpr_we ? ctpr_wdata : ctpr_q;

  always_comb begin
    raised_n = raised_q;
    svc_n    = svc_q;
    act_n    = act_q;
    if (ack_re && r_hit && !src_level[r_idx]) raised_n[r_idx] = 1'b0;
    if (req_valid) begin
      if (is_norm[req_id]) begin
        if (src_level[req_id])  raised_n[req_id] = req_level;
        else if (req_level)     raised_n[req_id] = 1'b1;
      end else if (src_level[req_id]) begin
        act_n[req_id] = req_level;
      end
    end
    if (eoi_we && s_hit) svc_n[s_idx] = 1'b0;
    if (ack_grant)       svc_n[r_idx] = 1'b1;
  end

  assign {nr_hit, nr_idx} = pick(raised_n, src_prio);
  assign {ns_hit, ns_idx} = pick(svc_n, src_prio);

  wire irq_n = nr_hit && (prio[nr_idx] > ctpr_n) &&
               (!ns_hit || prio[nr_idx] > prio[ns_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raised_q    <= '0;
      svc_q       <= '0;
      act_q       <= '0;
      ctpr_q      <= '1;
      irq_q       <= 1'b0;
      crit_q      <= 1'b0;
      mc_q        <= 1'b0;
      ack_vec_q   <= '0;
      ack_valid_q <= 1'b0;
    end else begin
      raised_q    <= raised_n;
      svc_q       <= svc_n;
      act_q       <= act_n;
      ctpr_q      <= ctpr_n;
      irq_q       <= irq_n;
      crit_q      <= |(act_n & is_crit);
      mc_q        <= |(act_n & is_mc);
      ack_valid_q <= ack_re;
      if (ack_re) ack_vec_q <= ack_grant ? vec[r_idx] : SPUR_VEC;
    end
  end

  assign ctpr_o    = ctpr_q;
  assign irq_o     = irq_q;
  assign crit_o    = crit_q;
  assign mcheck_o  = mc_q;
  assign ack_vec   = ack_vec_q;
  assign ack_valid = ack_valid_q;

endmodule

// File: rtl/irq_presenter_chk.sv
module irq_presenter_chk #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              ctpr_we,
  input logic [PRIO_W-1:0] ctpr_wdata,
  input logic [PRIO_W-1:0] ctpr_o,
  input logic              ack_re,
  input logic              ack_valid,
  input logic              eoi_we,
  input logic              irq_o,
  input logic [NSRC-1:0]   svc_q
);

  // R3
  ctpr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctpr_we |=> ctpr_o == $past(ctpr_wdata));

  // R3
  top_ctpr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctpr_o == {PRIO_W{1'b1}}) |-> !irq_o);

  // R5
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_re && !req_valid && !ctpr_we && !eoi_we) |=> !irq_o);

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_re |=> ack_valid);

  // R5
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_re |=> !ack_valid);

  // R7
  eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_we && !ack_re && svc_q == '0) |=> svc_q == '0);

  // R7
  eoi_retire_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_we && !ack_re && svc_q != '0) |=>
      $countones(svc_q) == $countones($past(svc_q)) - 1);

endmodule

bind irq_presenter irq_presenter_chk #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ctpr_we(ctpr_we),
  .ctpr_wdata(ctpr_wdata), .ctpr_o(ctpr_o), .ack_re(ack_re),
  .ack_valid(ack_valid), .eoi_we(eoi_we), .irq_o(irq_o), .svc_q(svc_q)
);

// File: tb/irq_presenter_tb_top.sv
`timescale 1ns/1ps
module irq_presenter_tb_top;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic [N*4-1:0] src_prio = '0;
  logic [N*8-1:0] src_vec;
  logic [N-1:0]   src_level = '0;
  logic [2*N-1:0] src_route = '0;
  logic req_valid = 0, req_level = 0, ctpr_we = 0, ack_re = 0, eoi_we = 0;
  logic [2:0] req_id = '0;
  logic [3:0] ctpr_wdata = '0, ctpr_o;
  logic ack_valid, irq_o, crit_o, mcheck_o;
  logic [7:0] ack_vec;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  irq_presenter dut_i (
    .clk(clk), .rst_n(rst_n), .src_prio(src_prio), .src_vec(src_vec),
    .src_level(src_level), .src_route(src_route), .req_valid(req_valid),
    .req_id(req_id), .req_level(req_level), .ctpr_we(ctpr_we),
    .ctpr_wdata(ctpr_wdata), .ctpr_o(ctpr_o), .ack_re(ack_re),
    .ack_valid(ack_valid), .ack_vec(ack_vec), .eoi_we(eoi_we),
    .irq_o(irq_o), .crit_o(crit_o), .mcheck_o(mcheck_o)
  );

  for (genvar g = 0; g < N; g++) begin : g_vec
    assign src_vec[g*8 +: 8] = 8'h40 + 8'(g);
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic req(int id, bit lvl);
    req_valid = 1; req_id = 3'(id); req_level = lvl;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic set_ctpr(int v);
    ctpr_we = 1; ctpr_wdata = 4'(v);
    @(negedge clk);
    ctpr_we = 0;
  endtask

  task automatic ack(string tag, int exp);
    ack_re = 1;
    @(negedge clk);
    ack_re = 0;
    check({tag, " ack_valid"}, int'(ack_valid), 1);
    check({tag, " ack_vec"}, int'(ack_vec), exp);
  endtask

  task automatic eoi();
    eoi_we = 1;
    @(negedge clk);
    eoi_we = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctpr", int'(ctpr_o), 15);
    check("R1 irq", int'(irq_o), 0);
    check("R1 crit", int'(crit_o), 0);
    check("R1 mcheck", int'(mcheck_o), 0);
    check("R1 ack_valid", int'(ack_valid), 0);
    ack("R1 empty", 8'hFF);

    // R2 R3 R5 R6: sweep source priority against task priority, edge source 0
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 16; c++) begin
        src_prio[3:0] = 4'(p);
        set_ctpr(15);
        req(0, 1);
        check("R2 held below ctpr", int'(irq_o), 0);
        set_ctpr(c);
        check("R3 sweep irq", int'(irq_o), (p > c) ? 1 : 0);
        ack("R5 sweep", (p > c) ? 8'h40 : 8'hFF);
        check("R6 edge dropped after ack", int'(irq_o), 0);
        if (p > c) eoi();
        set_ctpr(0);
        check("R6 edge not re-presented", int'(irq_o), 0);
      end
    end
    src_prio[3:0] = 4'd0;

    // R4 tie between sources 3 and 5
    src_prio[12 +: 4] = 4'd7;
    src_prio[20 +: 4] = 4'd7;
    req(5, 1);
    req(3, 1);
    check("R4 tie irq", int'(irq_o), 1);
    ack("R4 lowest wins", 8'h43);
    eoi();
    check("R4 second presented", int'(irq_o), 1);
    ack("R4 second", 8'h45);
    eoi();
    check("R4 drained", int'(irq_o), 0);

    // R6 level source 2 stays raised
    src_level[2] = 1'b1;
    src_prio[8 +: 4] = 4'd9;
    req(2, 1);
    ack("R6 level", 8'h42);
    check("R6 level hidden by itself", int'(irq_o), 0);
    eoi();
    check("R6 level still raised", int'(irq_o), 1);
    ack("R6 level again", 8'h42);
    req(2, 0);
    eoi();
    check("R6 level cleared", int'(irq_o), 0);
    ack("R6 level gone", 8'hFF);

    // R6 clear request to edge source 1 ignored
    src_prio[4 +: 4] = 4'd6;
    req(1, 1);
    req(1, 0);
    check("R6 edge clear ignored", int'(irq_o), 1);
    ack("R6 edge clear ignored", 8'h41);
    eoi();

    // R8 nested preemption, R7 retire order
    src_prio[16 +: 4] = 4'd3;
    src_prio[24 +: 4] = 4'd10;
    src_prio[28 +: 4] = 4'd5;
    req(4, 1);
    check("R3 low source", int'(irq_o), 1);
    ack("R8 first", 8'h44);
    check("R8 after first ack", int'(irq_o), 0);
    req(6, 1);
    check("R8 preempt", int'(irq_o), 1);
    ack("R8 nested", 8'h46);
    req(7, 1);
    check("R3 hidden by in-service", int'(irq_o), 0);
    eoi();
    check("R7 highest retired", int'(irq_o), 1);
    ack("R7 middle", 8'h47);
    eoi();
    eoi();
    check("R7 stack empty", int'(irq_o), 0);
    eoi();
    src_prio[0 +: 4] = 4'd1;
    req(0, 1);
    check("R7 empty eoi ignored", int'(irq_o), 1);
    ack("R7 after empty eoi", 8'h40);
    eoi();

    // R9 non-normal routes
    src_route[2 +: 2] = 2'd1; src_level[1] = 1'b1;
    src_route[4 +: 2] = 2'd1; src_level[2] = 1'b1;
    src_route[6 +: 2] = 2'd2; src_level[3] = 1'b1;
    src_route[10 +: 2] = 2'd1; src_level[5] = 1'b0;
    set_ctpr(15);
    req(5, 1);
    check("R9 edge on critical ignored", int'(crit_o), 0);
    req(1, 1);
    check("R9 critical on", int'(crit_o), 1);
    check("R9 normal untouched", int'(irq_o), 0);
    req(2, 1);
    req(1, 0);
    check("R9 count keeps line", int'(crit_o), 1);
    ack("R9 ack ignores critical", 8'hFF);
    req(2, 0);
    check("R9 critical off", int'(crit_o), 0);
    req(3, 1);
    check("R9 mcheck on", int'(mcheck_o), 1);
    check("R9 mcheck not critical", int'(crit_o), 0);
    req(3, 0);
    check("R9 mcheck off", int'(mcheck_o), 0);

    finish_run();
  end
endmodule